// File: doc/BRIEF.md
# Single-Cycle Six-Operation RISC Core

This block is a small non-pipelined processor that finishes one instruction on every clock edge, strictly in program order. Each cycle it presents its program counter on `pc`. The instruction word at that address arrives combinationally on `instr` from an instruction store outside the block. The core reads up to two registers, computes a result and commits it at the next rising edge. Arithmetic works only on registers. Only the load and store operations reach the internal word-addressed data memory. The only control transfer is a jump taken when a register holds zero, and its target comes from a second register.

The core has no streamed data path. Fetch is a combinational address-to-word lookup, and the observation pins are plain per-cycle signals. For that reason no valid/ready handshake or back-pressure applies. The observation pins describe the write that the current instruction will commit at the coming edge. A halt operation freezes the program counter so that an environment can see the end of a program.

Instruction layout: bits [15:13] hold the opcode, [12:9] the destination register, [8:5] source register A, [4:1] source register B, and [0] the low bit of the ALU function. Load-constant uses bits [7:0] as its immediate and ignores bit 8.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the PC, all 16 registers and every data-memory word are cleared to zero. After release, the first instruction fetched is at address 0 and reads zeros from all state.
- R2: Every opcode other than the jump (100) and halt (111) moves the PC to PC+1, modulo 2^PC_W, so 255 wraps to 0 with the defaults.
- R3: Opcode 000 writes the zero-extended immediate in bits [7:0] into the register named by bits [12:9].
- R4: Opcode 001 writes the zero-extended address of the instruction itself into the register named by bits [12:9].
- R5: Opcodes 010 and 011 combine register A (bits [8:5]) and register B (bits [4:1]) and write the result into the destination register (bits [12:9]). The function code {opcode bit 13, bit 0} selects the operation: 00 is A+B, 01 is A−B, 10 is A AND B and 11 is A XOR B. Results wrap to DATA_W bits.
- R6: Opcode 100 tests register A (bits [8:5]). If it is zero, the PC becomes the low PC_W bits of register B (bits [4:1]). Otherwise the PC becomes PC+1. The jump writes neither a register nor memory.
- R7: Opcode 101 loads the data word at the address formed by the low DM_AW bits of register A (bits [8:5]) into the destination register (bits [12:9]).
- R8: Opcode 110 stores register B (bits [4:1]) into the data word at the address formed by the low DM_AW bits of register A (bits [8:5]). It writes no register. `dm_we`, `dm_addr` and `dm_wdata` show the store during its cycle.
- R9: Opcode 111 holds the PC, raises `halted` and performs no register or memory write.
- R10: `rf_we`, `rf_waddr` and `rf_wdata` show the current instruction's register write, which takes effect at the next rising edge. A source register that is also the destination supplies its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction word at address `pc` |
| pc | output | PC_W | Address of the current instruction |
| halted | output | 1 | Current instruction is halt |
| rf_we | output | 1 | Register write at the next edge |
| rf_waddr | output | 4 | Register being written |
| rf_wdata | output | DATA_W | Value being written to the register |
| dm_we | output | 1 | Data-memory write at the next edge |
| dm_addr | output | DM_AW | Data-memory word address of the store |
| dm_wdata | output | DATA_W | Value being stored |

## Verification
The bench targets these corner cases:
- A taken jump whose target register holds a value wider than the PC. A core that fails to truncate it would jump to the wrong place.
- The PC wrapping from its top address to zero.
- A subtraction that underflows.
- A destination register that is also a source. A core that forwarded the new value would double-count.
- A load and store through an address whose upper bits must be dropped.
- Halt. A wrong halt would keep fetching or leave write strobes raised.

A reset issued after a program has dirtied registers and memory must leave all of them at zero. A core that skipped clearing any of them would return stale data on the next loads and arithmetic.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int INSTR_W = 16;
  localparam int RIDX_W  = 4;
  localparam int IMM_W   = 8;

  typedef enum logic [2:0] {
    OP_LDI  = 3'b000,
    OP_LDPC = 3'b001,
    OP_ALU0 = 3'b010,
    OP_ALU1 = 3'b011,
    OP_JZ   = 3'b100,
    OP_LD   = 3'b101,
    OP_ST   = 3'b110,
    OP_HALT = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_AND, FN_XOR} alu_fn_e;
  typedef enum logic [1:0] {WB_IMM, WB_PC, WB_ALU, WB_MEM} wb_sel_e;

  typedef struct packed {
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [IMM_W-1:0]  imm;
    alu_fn_e           fn;
    wb_sel_e           wb;
    logic              reg_wr;
    logic              mem_wr;
    logic              is_jz;
    logic              is_halt;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);
  opcode_e op;

  always_comb begin
    op           = opcode_e'(instr[15:13]);
    ctrl.rd      = instr[12:9];
    ctrl.rs1     = instr[8:5];
    ctrl.rs2     = instr[4:1];
    ctrl.imm     = instr[7:0];
    ctrl.fn      = alu_fn_e'({instr[13], instr[0]});
    ctrl.wb      = WB_ALU;
    ctrl.reg_wr  = 1'b0;
    ctrl.mem_wr  = 1'b0;
    ctrl.is_jz   = 1'b0;
    ctrl.is_halt = 1'b0;
    case (op)
      OP_LDI:           begin ctrl.reg_wr = 1'b1; ctrl.wb = WB_IMM; end
      OP_LDPC:          begin ctrl.reg_wr = 1'b1; ctrl.wb = WB_PC;  end
      OP_ALU0, OP_ALU1: begin ctrl.reg_wr = 1'b1; ctrl.wb = WB_ALU; end
      OP_JZ:            ctrl.is_jz   = 1'b1;
      OP_LD:            begin ctrl.reg_wr = 1'b1; ctrl.wb = WB_MEM; end
      OP_ST:            ctrl.mem_wr  = 1'b1;
      default:          ctrl.is_halt = 1'b1;
    endcase
  end

  // R9: at most one kind of effect per instruction
  always_comb begin
    one_effect_chk: assert ($onehot0({ctrl.reg_wr, ctrl.mem_wr, ctrl.is_jz, ctrl.is_halt}));
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_fn_e           fn,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int NREG = 1 << IDX_W;

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (we && waddr == IDX_W'(g))   regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  // R10
  rf_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[g] <= '0;
      else if (we && addr == ADDR_W'(g)) mem[g] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // R8
  st_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 8,
  parameter int DM_AW  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         instr,
  output logic [PC_W-1:0]     pc,
  output logic                halted,
  output logic                rf_we,
  output logic [3:0]          rf_waddr,
  output logic [DATA_W-1:0]   rf_wdata,
  output logic                dm_we,
  output logic [DM_AW-1:0]    dm_addr,
  output logic [DATA_W-1:0]   dm_wdata
);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  ctrl_t             ctrl;
  logic [PC_W-1:0]   pc_q, pc_d, pc_inc;
  logic [DATA_W-1:0] a_val, b_val, alu_y, ld_val, wb_val;
  logic              a_zero;

  sc_decode u_dec (.instr(instr), .ctrl(ctrl));

  sc_regfile #(.DATA_W(DATA_W), .IDX_W(RIDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(ctrl.reg_wr), .waddr(ctrl.rd), .wdata(wb_val),
    .raddr_a(ctrl.rs1), .rdata_a(a_val),
    .raddr_b(ctrl.rs2), .rdata_b(b_val)
  );

  sc_alu #(.DATA_W(DATA_W)) u_alu (.a(a_val), .b(b_val), .fn(ctrl.fn), .y(alu_y));

  sc_dmem #(.DATA_W(DATA_W), .ADDR_W(DM_AW)) u_dm (
    .clk(clk), .rst_n(rst_n),
    .we(ctrl.mem_wr), .addr(a_val[DM_AW-1:0]), .wdata(b_val), .rdata(ld_val)
  );

  always_comb begin
    case (ctrl.wb)
      WB_IMM:  wb_val = DATA_W'(ctrl.imm);
      WB_PC:   wb_val = DATA_W'(pc_q);
      WB_ALU:  wb_val = alu_y;
      default: wb_val = ld_val;
    endcase
  end

  assign a_zero = (a_val == '0);
  assign pc_inc = pc_q + PC_ONE;

  always_comb begin
    if (ctrl.is_halt)               pc_d = pc_q;
    else if (ctrl.is_jz && a_zero)  pc_d = b_val[PC_W-1:0];
    else                            pc_d = pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc       = pc_q;
  assign halted   = ctrl.is_halt;
  assign rf_we    = ctrl.reg_wr;
  assign rf_waddr = ctrl.rd;
  assign rf_wdata = wb_val;
  assign dm_we    = ctrl.mem_wr;
  assign dm_addr  = a_val[DM_AW-1:0];
  assign dm_wdata = b_val;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.is_jz && !halted) |=> pc == $past(pc) + PC_ONE);

  // R6
  jz_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.is_jz && a_val != '0) |=> pc == $past(pc) + PC_ONE);

  // R6
  jz_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.is_jz && a_val == '0) |=> pc == $past(b_val[PC_W-1:0]));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!rf_we && !dm_we));
endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
  localparam int DATA_W = 16;
  localparam int PC_W   = 8;
  localparam int DM_AW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] instr;
  logic [PC_W-1:0] pc;
  logic halted, rf_we, dm_we;
  logic [3:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata, dm_wdata;
  logic [DM_AW-1:0] dm_addr;

  logic [15:0] rom [256];
  logic [DATA_W-1:0] mrf [16];
  logic [DATA_W-1:0] mdm [32];
  logic [PC_W-1:0] mpc;
  string prev_tag;
  string ctx;
  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign instr = rom[pc];

  sc_core #(.DATA_W(DATA_W), .PC_W(PC_W), .DM_AW(DM_AW)) i_sc_core (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .halted(halted),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  function automatic logic [15:0] e_rrr(logic [2:0] op, int rd, int a, int b, bit f);
    return {op, 4'(rd), 4'(a), 4'(b), f};
  endfunction

  function automatic logic [15:0] e_ldi(int rd, int imm);
    return {3'b000, 4'(rd), 1'b0, 8'(imm)};
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare outputs with the reference step, then advance the model
  task automatic step_check();
    logic [15:0] w;
    logic [2:0] op;
    logic [3:0] rd, ra, rb;
    logic [DATA_W-1:0] va, vb, res;
    logic e_we, e_dwe;
    logic [PC_W-1:0] npc;
    string t;
    w = rom[mpc];
    op = w[15:13]; rd = w[12:9]; ra = w[8:5]; rb = w[4:1];
    va = mrf[ra]; vb = mrf[rb];
    e_we = 0; e_dwe = 0; res = '0;
    npc = mpc + 8'd1;
    case (op)
      3'd0: begin e_we = 1; res = DATA_W'(w[7:0]); end
      3'd1: begin e_we = 1; res = DATA_W'(mpc); end
      3'd2, 3'd3: begin
        e_we = 1;
        case ({op[0], w[0]})
          2'b00: res = va + vb;
          2'b01: res = va - vb;
          2'b10: res = va & vb;
          default: res = va ^ vb;
        endcase
      end
      3'd4: if (va == '0) npc = vb[PC_W-1:0];
      3'd5: begin e_we = 1; res = mdm[va[DM_AW-1:0]]; end
      3'd6: e_dwe = 1;
      default: npc = mpc;
    endcase
    t = (ctx != "") ? ctx : tag_of(op);
    chk(pc == mpc, prev_tag, "pc", 32'(pc), 32'(mpc));
    chk(halted == (op == 3'd7), "R9", "halted", 32'(halted), 32'(op == 3'd7));
    chk(rf_we == e_we, {"R10 ", t}, "rf_we", 32'(rf_we), 32'(e_we));
    if (e_we) begin
      chk(rf_waddr == rd, {"R10 ", t}, "rf_waddr", 32'(rf_waddr), 32'(rd));
      chk(rf_wdata == res, {"R10 ", t}, "rf_wdata", 32'(rf_wdata), 32'(res));
    end
    chk(dm_we == e_dwe, "R8", "dm_we", 32'(dm_we), 32'(e_dwe));
    if (e_dwe) begin
      chk(dm_addr == va[DM_AW-1:0], "R8", "dm_addr", 32'(dm_addr), 32'(va[DM_AW-1:0]));
      chk(dm_wdata == vb, "R8", "dm_wdata", 32'(dm_wdata), 32'(vb));
      mdm[va[DM_AW-1:0]] = vb;
    end
    if (e_we) mrf[rd] = res;
    prev_tag = (op == 3'd4) ? "R6" : (op == 3'd7) ? "R9" : "R2";
    mpc = npc;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) mrf[i] = '0;
    for (int i = 0; i < 32; i++) mdm[i] = '0;
    mpc = '0;
    prev_tag = "R1";
    rst_n = 1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      #1;
      step_check();
      @(negedge clk);
    end
  endtask

  task automatic fill_halt();
    for (int i = 0; i < 256; i++) rom[i] = 16'hE000;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    ctx = "";
    fill_halt();
    // Directed program covering every opcode and boundaries
    rom[0]  = e_ldi(1, 5);
    rom[1]  = e_ldi(2, 3);
    rom[2]  = e_rrr(3'd2, 3, 1, 2, 0);   // R5 add
    rom[3]  = e_rrr(3'd2, 4, 2, 1, 1);   // R5 sub underflow -> FFFE
    rom[4]  = e_rrr(3'd3, 5, 1, 2, 0);   // R5 and
    rom[5]  = e_rrr(3'd3, 6, 1, 2, 1);   // R5 xor
    rom[6]  = e_rrr(3'd2, 1, 1, 1, 0);   // R10 rd equals sources -> 10
    rom[7]  = {3'd1, 4'd7, 9'd0};        // R4 ldpc -> 7
    rom[8]  = e_rrr(3'd6, 0, 1, 3, 0);   // R8 store r3 at 10
    rom[9]  = e_rrr(3'd5, 8, 1, 0, 0);   // R7 load from 10
    rom[10] = e_ldi(9, 0);
    rom[11] = e_ldi(10, 255);
    rom[12] = e_rrr(3'd2, 10, 10, 10, 0); // 510
    rom[13] = e_rrr(3'd6, 0, 10, 4, 0);  // R8 address truncated to 30
    rom[14] = e_rrr(3'd5, 11, 10, 0, 0); // R7
    rom[15] = e_ldi(12, 20);
    rom[16] = e_rrr(3'd4, 0, 9, 12, 0);  // R6 taken to 20
    rom[17] = e_ldi(13, 99);
    rom[20] = e_rrr(3'd4, 0, 1, 12, 0);  // R6 not taken
    rom[21] = e_rrr(3'd4, 0, 9, 10, 0);  // R6 target 510 truncated to FE
    rom[254] = e_ldi(14, 8'hAB);
    rom[255] = {3'd1, 4'd15, 9'd0};      // R2 wrap 255 -> 0 follows
    do_reset();
    run(40);

    // R1: state cleared by a reset that follows a dirtying program
    fill_halt();
    for (int i = 0; i < 16; i++) rom[i] = e_rrr(3'd2, i, i, i, 0);
    rom[16] = e_ldi(1, 10);
    rom[17] = e_rrr(3'd5, 2, 1, 0, 0);
    rom[18] = e_ldi(3, 30);
    rom[19] = e_rrr(3'd5, 4, 3, 0, 0);
    do_reset();
    ctx = "R1";
    run(20);
    ctx = "";
    run(5);                              // R9 halt holds

    // Random programs
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 256; i++) begin
        logic [2:0] op;
        op = 3'($urandom_range(0, 7));
        if (op == 3'd7 && ($urandom % 6) != 0) op = 3'd2;
        rom[i] = {op, 13'($urandom)};
      end
      do_reset();
      run(200);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule